// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A sixteen-state controller is stepped by a mode input that is sampled on each rising edge of the test clock. Between the serial data input and the serial data output sits exactly one shift register at a time. That register is either a 3-bit instruction register, a single bypass flip-flop, a 32-bit identification word, or a boundary chain. The boundary chain captures the device's pin levels and a number of filler cells that always hold one.

No separate test-reset pin is provided. The controller returns to its reset state after an asynchronous power-on reset, or after the mode input has been high for five consecutive rising edges. Outputs change only on the falling edge, so a downstream device sees a full half period of setup time. The serial output is driven only while a register is actually shifting. When the port is left idle with both serial inputs held high, it stays in reset and does not disturb the device.

Top module: `scan_tap`

## Requirements
- R1: `tms`, `tdi` and `pin_levels` are sampled on the rising edge of `tck`; `tdo` and `tdo_en` change only on the falling edge of `tck`.
- R2: The controller follows the standard sixteen-state graph (reset, idle, select/capture/shift/exit1/pause/exit2/update for both the data and instruction columns), and every one of its 32 state/mode transitions is reachable.
- R3: With `por_n` low, or after `tms` has been high at five consecutive rising edges from any state, the controller is in the reset state.
- R4: The active instruction is 3 bits wide. It is set to the identification opcode 3'b001 by power-on reset and at every rising edge spent in the reset state, and it changes otherwise only in the instruction-update state. Instruction capture loads 3'b001 into the instruction shift register, which shifts out least significant bit first.
- R5: Opcode 3'b111 selects bypass, 3'b001 selects the identification word, and 3'b010 selects the boundary chain for sample/preload; every other opcode selects bypass.
- R6: The bypass register is one flip-flop that captures 0 in data capture and then delays `tdi` by exactly one `tck` period on its way to `tdo`.
- R7: The identification register captures the 32-bit constant `IDCODE_VALUE`, whose bit 0 must be 1, and shifts it out least significant bit first.
- R8: The boundary chain has `NUM_PINS + NUM_PAD` cells. Cell i (i < `NUM_PINS`) captures `pin_levels[i]`, and the cells above it capture 1. Cell 0 reaches `tdo` first, and `tdi` enters at the top cell.
- R9: `tdo_en` is high only in the two shift states, and `tdo` is 0 whenever `tdo_en` is low; both are low during power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| pin_levels | input | NUM_PINS | Device pin levels captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for `tdo` |

## Verification
The embedded properties check several things on every clock. They confirm that five high mode samples always end in reset, that the active instruction holds still outside the update and reset states, and that each capture loads its fixed pattern or pin values. They also confirm that bypass delays by one stage and that the output enable is never asserted outside a shift state. Other behaviour only shows up over a whole scenario, so the bench's sequences are needed for it. This includes every one of the 32 controller transitions being walked, the bit order of a full identification or boundary read-out, and the decode of each of the eight opcodes. It also includes the falling-edge timing relative to a rising-edge shift, which the bench compares against its own reference model on every half cycle.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   localparam int unsigned OPC_W = 3;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_IDLE,
      ST_DR_SEL,
      ST_DR_CAP,
      ST_DR_SHIFT,
      ST_DR_EXIT1,
      ST_DR_PAUSE,
      ST_DR_EXIT2,
      ST_DR_UPD,
      ST_IR_SEL,
      ST_IR_CAP,
      ST_IR_SHIFT,
      ST_IR_EXIT1,
      ST_IR_PAUSE,
      ST_IR_EXIT2,
      ST_IR_UPD
   } tap_state_e;

   typedef enum logic [1:0] {
      PATH_BYPASS,
      PATH_IDENT,
      PATH_BOUNDARY
   } dr_path_e;

   localparam logic [OPC_W-1:0] OPC_BYPASS     = 3'b111;
   localparam logic [OPC_W-1:0] OPC_IDENT      = 3'b001;
   localparam logic [OPC_W-1:0] OPC_SAMPLE     = 3'b010;
   localparam logic [OPC_W-1:0] IR_CAPTURE_PAT = 3'b001;

   // Unused opcodes fall back to the one-bit path (R5)
   function automatic dr_path_e decode_opcode(input logic [OPC_W-1:0] op);
      dr_path_e p;
      case (op)
         OPC_IDENT:  p = PATH_IDENT;
         OPC_SAMPLE: p = PATH_BOUNDARY;
         default:    p = PATH_BYPASS;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
         ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
         ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
         ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
         ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
         ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
         ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
         ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
         ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
         ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
         ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
         ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
         default:     state_d = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state_q <= ST_RESET;
      else        state_q <= state_d;
   end

   assign state = state_q;

   // Run length of consecutive high mode samples, saturating; checker only
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)              hi_run <= 3'd0;
      else if (!tms)           hi_run <= 3'd0;
      else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
   end

   a_r3_five_high_resets: assert property (@(posedge tck) disable iff (!por_n)
      (hi_run >= 3'd5) |-> (state_q == ST_RESET));

   a_r2_reset_exits_low: assert property (@(posedge tck) disable iff (!por_n)
      (state_q == ST_RESET && !tms) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
   import scan_tap_pkg::*;
(
   input  logic             tck,
   input  logic             por_n,
   input  tap_state_e       state,
   input  logic             tdi,
   output logic [OPC_W-1:0] opcode,
   output logic             ir_lsb
);

   logic [OPC_W-1:0] sr_q;
   logic [OPC_W-1:0] ir_q;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         sr_q <= IR_CAPTURE_PAT;
      end else begin
         case (state)
            ST_IR_CAP:   sr_q <= IR_CAPTURE_PAT;
            ST_IR_SHIFT: sr_q <= {tdi, sr_q[OPC_W-1:1]};
            default:     sr_q <= sr_q;
         endcase
      end
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                  ir_q <= OPC_IDENT;
      else if (state == ST_RESET)  ir_q <= OPC_IDENT;
      else if (state == ST_IR_UPD) ir_q <= sr_q;
   end

   assign opcode = ir_q;
   assign ir_lsb = sr_q[0];

   a_r4_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_IR_CAP) |=> (sr_q == 3'b001));

   a_r4_ir_holds: assert property (@(posedge tck) disable iff (!por_n)
      (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir_q));

   a_r4_reset_preload: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_RESET) |=> (ir_q == 3'b001));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
   import scan_tap_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 8,
   parameter int unsigned NUM_PAD      = 2,
   parameter logic [31:0] IDCODE_VALUE = 32'h2B7C_90A5
) (
   input  logic                tck,
   input  logic                por_n,
   input  tap_state_e          state,
   input  logic [OPC_W-1:0]    opcode,
   input  logic                tdi,
   input  logic [NUM_PINS-1:0] pin_levels,
   output logic                dr_lsb
);

   localparam int unsigned CHAIN_LEN = NUM_PINS + NUM_PAD;
   localparam int unsigned ID_W      = 32;

   dr_path_e path;
   assign path = decode_opcode(opcode);

   logic                  byp_q;
   logic [ID_W-1:0]       id_q;
   logic [CHAIN_LEN-1:0]  chain_q;
   logic [CHAIN_LEN-1:0]  cap_vec;

   // Per-cell capture source: pin level for real cells, constant one for fillers
   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      if (i < NUM_PINS) begin : g_pin
         assign cap_vec[i] = pin_levels[i];
      end else begin : g_fill
         assign cap_vec[i] = 1'b1;
      end
   end

   logic cap_en, shf_en;
   assign cap_en = (state == ST_DR_CAP);
   assign shf_en = (state == ST_DR_SHIFT);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         byp_q <= 1'b0;
      end else if (path == PATH_BYPASS) begin
         if (cap_en)      byp_q <= 1'b0;
         else if (shf_en) byp_q <= tdi;
      end
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         id_q <= '0;
      end else if (path == PATH_IDENT) begin
         if (cap_en)      id_q <= IDCODE_VALUE;
         else if (shf_en) id_q <= {tdi, id_q[ID_W-1:1]};
      end
   end

   generate
      if (CHAIN_LEN > 1) begin : g_long_chain
         always_ff @(posedge tck or negedge por_n) begin
            if (!por_n) begin
               chain_q <= '0;
            end else if (path == PATH_BOUNDARY) begin
               if (cap_en)      chain_q <= cap_vec;
               else if (shf_en) chain_q <= {tdi, chain_q[CHAIN_LEN-1:1]};
            end
         end
      end else begin : g_one_cell
         always_ff @(posedge tck or negedge por_n) begin
            if (!por_n) begin
               chain_q <= '0;
            end else if (path == PATH_BOUNDARY) begin
               if (cap_en)      chain_q <= cap_vec;
               else if (shf_en) chain_q <= tdi;
            end
         end
      end
   endgenerate

   always_comb begin
      case (path)
         PATH_IDENT:    dr_lsb = id_q[0];
         PATH_BOUNDARY: dr_lsb = chain_q[0];
         default:       dr_lsb = byp_q;
      endcase
   end

   a_r6_bypass_delay: assert property (@(posedge tck) disable iff (!por_n)
      (shf_en && path == PATH_BYPASS) |=> (byp_q == $past(tdi)));

   a_r6_bypass_capture: assert property (@(posedge tck) disable iff (!por_n)
      (cap_en && path == PATH_BYPASS) |=> (byp_q == 1'b0));

   a_r7_ident_capture: assert property (@(posedge tck) disable iff (!por_n)
      (cap_en && path == PATH_IDENT) |=> (id_q == IDCODE_VALUE));

   a_r8_pins_capture: assert property (@(posedge tck) disable iff (!por_n)
      (cap_en && path == PATH_BOUNDARY) |=> (chain_q[NUM_PINS-1:0] == $past(pin_levels)));

   if (NUM_PAD > 0) begin : g_fill_chk
      a_r8_filler_ones: assert property (@(posedge tck) disable iff (!por_n)
         (cap_en && path == PATH_BOUNDARY) |=> (&chain_q[CHAIN_LEN-1:NUM_PINS]));
   end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
   import scan_tap_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 8,
   parameter int unsigned NUM_PAD      = 2,
   parameter logic [31:0] IDCODE_VALUE = 32'h2B7C_90A5
) (
   input  logic                tck,
   input  logic                por_n,
   input  logic                tms,
   input  logic                tdi,
   input  logic [NUM_PINS-1:0] pin_levels,
   output logic                tdo,
   output logic                tdo_en
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("scan_tap: NUM_PINS must be at least 1");
   end
   if (IDCODE_VALUE[0] != 1'b1) begin : g_bad_id
      $error("scan_tap: IDCODE_VALUE bit 0 must be 1");
   end

   tap_state_e       state;
   logic [OPC_W-1:0] opcode;
   logic             ir_lsb;
   logic             dr_lsb;

   scan_tap_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   scan_tap_ir u_ir (
      .tck    (tck),
      .por_n  (por_n),
      .state  (state),
      .tdi    (tdi),
      .opcode (opcode),
      .ir_lsb (ir_lsb)
   );

   scan_tap_dr #(
      .NUM_PINS     (NUM_PINS),
      .NUM_PAD      (NUM_PAD),
      .IDCODE_VALUE (IDCODE_VALUE)
   ) u_dr (
      .tck        (tck),
      .por_n      (por_n),
      .state      (state),
      .opcode     (opcode),
      .tdi        (tdi),
      .pin_levels (pin_levels),
      .dr_lsb     (dr_lsb)
   );

   logic shifting, serial_bit;
   assign shifting   = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
   assign serial_bit = (state == ST_IR_SHIFT) ? ir_lsb : dr_lsb;

   // Output stage retimed to the falling edge (R1)
   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo    <= shifting ? serial_bit : 1'b0;
         tdo_en <= shifting;
      end
   end

   a_r9_enable_in_shift: assert property (@(posedge tck) disable iff (!por_n)
      tdo_en |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

   a_r9_quiet_when_off: assert property (@(posedge tck) disable iff (!por_n)
      !tdo_en |-> !tdo);

endmodule

// File: tb/sim_scan_tap.sv
module sim_scan_tap;

   localparam int NP = 8;
   localparam int NX = 2;
   localparam int CL = NP + NX;
   localparam logic [31:0] IDV = 32'h6D31_C4E7;

   logic tck = 1'b0;
   logic por_n = 1'b0;
   logic tms = 1'b1;   // idle inputs held high, as an undriven pin would read
   logic tdi = 1'b1;
   logic [NP-1:0] pins = '0;
   logic tdo, tdo_en;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   scan_tap #(.NUM_PINS(NP), .NUM_PAD(NX), .IDCODE_VALUE(IDV)) u0 (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
      .pin_levels(pins), .tdo(tdo), .tdo_en(tdo_en)
   );

   always #4 tck = ~tck;   // 125 MHz

   // Reference model, states numbered independently of the design
   int ms = 0;
   logic [2:0]    m_ir = 3'b001, m_irsr = 3'b001;
   logic          m_byp = 1'b0;
   logic [31:0]   m_id = '0;
   logic [CL-1:0] m_bs = '0;
   logic [31:0]   seen = '0;

   function automatic int nxt(input int s, input logic t);
      case (s)
         0: return t ? 0 : 1;    1: return t ? 2 : 1;
         2: return t ? 9 : 3;    3: return t ? 5 : 4;
         4: return t ? 5 : 4;    5: return t ? 8 : 6;
         6: return t ? 7 : 6;    7: return t ? 8 : 4;
         8: return t ? 2 : 1;    9: return t ? 0 : 10;
         10: return t ? 12 : 11; 11: return t ? 12 : 11;
         12: return t ? 15 : 13; 13: return t ? 14 : 13;
         14: return t ? 15 : 11; default: return t ? 2 : 1;
      endcase
   endfunction

   function automatic int path_of(input logic [2:0] op);
      if (op == 3'b001) return 1;
      if (op == 3'b010) return 2;
      return 0;
   endfunction

   task automatic model_step(input logic t, input logic d);
      int p;
      p = path_of(m_ir);
      case (ms)
         0:  m_ir = 3'b001;
         10: m_irsr = 3'b001;
         11: m_irsr = {d, m_irsr[2:1]};
         15: m_ir = m_irsr;
         3: begin
            if (p == 0) m_byp = 1'b0;
            else if (p == 1) m_id = IDV;
            else m_bs = {{NX{1'b1}}, pins};
         end
         4: begin
            if (p == 0) m_byp = d;
            else if (p == 1) m_id = {d, m_id[31:1]};
            else m_bs = {d, m_bs[CL-1:1]};
         end
         default: ;
      endcase
      seen[ms*2 + int'(t)] = 1'b1;
      ms = nxt(ms, t);
   endtask

   function automatic logic exp_tdo();
      int p;
      p = path_of(m_ir);
      if (ms == 11) return m_irsr[0];
      if (ms == 4) return (p == 0) ? m_byp : (p == 1) ? m_id[0] : m_bs[0];
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // One test-clock period, entered and left just after a falling edge
   task automatic cyc(input logic t, input logic d, output logic o);
      logic pt, pe, et, ee;
      tms = t; tdi = d;
      pt = tdo; pe = tdo_en;
      @(posedge tck); #1;
      chk(tdo === pt && tdo_en === pe, "R1 outputs steady at rising edge", {tdo, tdo_en}, {pt, pe});
      model_step(t, d);
      et = exp_tdo();
      ee = (ms == 4 || ms == 11);
      @(negedge tck); #1;
      chk(tdo_en === ee, "R9 tdo_en", tdo_en, ee);
      chk(tdo === et, "R1 tdo after falling edge", tdo, et);
      o = tdo;
   endtask

   task automatic step(input logic t);
      logic o;
      cyc(t, 1'b1, o);
   endtask

   task automatic go_idle();
      for (int i = 0; i < 5; i++) step(1'b1);
      step(1'b0);
   endtask

   // From idle: load an opcode, return the 3 captured bits
   task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
      logic o;
      step(1'b1); step(1'b1); step(1'b0);
      cyc(1'b0, 1'b1, o); cap[0] = o;
      for (int k = 0; k < 3; k++) begin
         cyc(k == 2, op[k], o);
         if (k < 2) cap[k+1] = o;
      end
      step(1'b1); step(1'b0);
   endtask

   // From idle: capture and shift n data bits
   task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      logic o;
      dout = '0;
      step(1'b1); step(1'b0);
      cyc(1'b0, 1'b1, o); dout[0] = o;
      for (int k = 0; k < n; k++) begin
         cyc(k == n - 1, din[k], o);
         if (k < n - 1) dout[k+1] = o;
      end
      step(1'b1); step(1'b0);
   endtask

   function automatic logic [63:0] mask(input int n);
      return (64'd1 << n) - 64'd1;
   endfunction

   initial begin
      logic [2:0] cap;
      logic [63:0] din, dout, exp;
      logic o;
      int n, p;
      void'($urandom(32'd4711));
      #3;
      chk(tdo === 1'b0 && tdo_en === 1'b0, "R9 reset outputs", {tdo, tdo_en}, 2'b00);
      #7 por_n = 1'b1;
      @(negedge tck); #1;
      chk(tdo_en === 1'b0, "R3 idle after power-on", tdo_en, 1'b0);

      // Random walk over the controller graph with random data and pins
      for (int i = 0; i < 4000; i++) begin
         pins = NP'($urandom);
         cyc(1'($urandom), 1'($urandom), o);
      end
      chk(seen === 32'hFFFF_FFFF, "R2 all transitions walked", seen, 32'hFFFF_FFFF);

      // Five high samples from arbitrary states restore the identification opcode
      for (int r = 0; r < 24; r++) begin
         go_idle();
         load_ir(3'b111, cap);
         for (int i = 0; i < r % 11; i++) step(1'($urandom));
         go_idle();
         din = {$urandom, $urandom};
         shift_dr(32, din, dout);
         chk(dout[31:0] === IDV, "R3 five-high reset reloads ident", dout[31:0], IDV);
      end

      // Every opcode with several data and pin patterns
      for (int round = 0; round < 3; round++) begin
         for (int op = 0; op < 8; op++) begin
            pins = (round == 0) ? '0 : (round == 1) ? '1 : NP'($urandom);
            load_ir(3'(op), cap);
            chk(cap === 3'b001, "R4 instruction capture pattern", cap, 3'b001);
            p = path_of(3'(op));
            n = (p == 0) ? 12 : (p == 1) ? 32 : CL;
            din = {$urandom, $urandom};
            shift_dr(n, din, dout);
            if (p == 0)      exp = (din << 1) & mask(n);
            else if (p == 1) exp = 64'(IDV);
            else             exp = 64'({{NX{1'b1}}, pins});
            if (p == 0)      chk((dout & mask(n)) === exp, "R6 bypass one-stage delay (R5 decode)", dout & mask(n), exp);
            else if (p == 1) chk((dout & mask(n)) === exp, "R7 ident readout (R5 decode)", dout & mask(n), exp);
            else             chk((dout & mask(n)) === exp, "R8 boundary readout (R5 decode)", dout & mask(n), exp);
         end
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(64'd8 * 64'd200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule